// File: doc/BRIEF.md
# Mantissa-Exponent Wake-Up Timer

This block is a low-power periodic wake-up timer. Software programs it with a 16-bit command word; a word whose three most significant bits are all ones is a timer command and carries a 5-bit exponent and an 8-bit mantissa. Once enabled, the timer counts a slow millisecond-scale tick. It raises a wake-up event after mantissa × 2^exponent ticks, which gives a nominal period of about 1.03 ms × M × 2^R plus half a millisecond on the intended tick source.

The exponent drives a shift prescaler that divides the tick by 2^R. An 8-bit mantissa counter follows the prescaler and counts its wraps. The timer runs only while the wake-up enable bit from power management is high. Each expiry produces a one-cycle pulse and sets a sticky status flag. The flag stays set until the status read acknowledge clears it. After each expiry the timer reloads and runs again.

Top module: `wake_timer`

## Requirements
- R1: A write with `cmd_word[15:13]` = 3'b111 loads the exponent from `cmd_word[12:8]` and the mantissa from `cmd_word[7:0]`. A write with any other top-three-bit value has no effect on the count or the settings.
- R2: With enable high and mantissa M > 0, `wake_pulse` is high for exactly one clock in the cycle after the clock that carries the (M·2^R)-th tick counted since the last restart.
- R3: Every exponent from 0 to 31 is accepted, and the prescaler divides the tick by 2^R.
- R4: A mantissa of zero never produces `wake_pulse`.
- R5: Every timer command write restarts the count from zero, even when it rewrites the same values.
- R6: `wake_flag` is set one cycle after `wake_pulse` and holds until `flag_clr`. If a set and a clear arrive in the same cycle, the set wins.
- R7: While `wut_en` is low, no ticks are counted and no pulse occurs. When `wut_en` goes high again, counting starts from zero.
- R8: After an expiry the timer reloads and fires again every M·2^R ticks for as long as it stays enabled.
- R9: After reset the exponent and mantissa are zero, and `wake_pulse` and `wake_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-clock strobe from the slow time base |
| wut_en | input | 1 | Wake-up timer enable bit from power management |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| flag_clr | input | 1 | Status read acknowledge that clears the flag |
| wake_pulse | output | 1 | One-cycle wake-up event |
| wake_flag | output | 1 | Sticky wake-up status flag |

## Verification
The bench sweeps exponents 0 to 4 against mantissas 1 to 6. For each pair it counts ticks from the restart, so an off-by-one in either counter shows up as a misplaced first or second pulse, and a shift error shows up as a wrong multiple. A zero mantissa and a very large exponent show that no pulse is produced. A restart midway through a count separates a real restart from a write that is ignored: it is done once with a rewrite of the same timer command, once with a non-timer command, and once by toggling the enable. Flag checks cover holding, clearing, and the case where a set and a clear land in the same cycle.

// File: rtl/wake_timer_pkg.sv
// Package: shared widths and the command-decode helper for the wake-up timer.
// Assumes the command word is 16 bits with the opcode in its top three bits.
package wake_timer_pkg;
    localparam int CMD_W = 16;
    localparam logic [2:0] TIMER_OP = 3'b111;

    // True when a command word addresses the wake-up timer.
    function automatic logic is_timer_cmd(input logic [CMD_W-1:0] w);
        return w[CMD_W-1 -: 3] == TIMER_OP;
    endfunction
endpackage

// File: rtl/wake_timer_cfg.sv
// Module: holds the exponent and mantissa and issues a restart on each timer write.
// Assumes the exponent sits just below the opcode and the mantissa in the low bits.
module wake_timer_cfg
    import wake_timer_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int MANT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [EXP_W-1:0]  exp_q,
    output logic [MANT_W-1:0] mant_q,
    output logic              restart
);
    logic hit;

    // Decode: a write counts only when its opcode selects the timer.
    always_comb begin
        hit     = cmd_we && is_timer_cmd(cmd_word);
        restart = hit;
    end

    // Settings register: load both fields on every timer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            mant_q <= '0;
        end else if (hit) begin
            exp_q  <= cmd_word[MANT_W +: EXP_W];
            mant_q <= cmd_word[MANT_W-1:0];
        end
    end

    // R1: non-timer writes leave settings untouched
    p_ignore_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[CMD_W-1 -: 3] != 3'b111) |=> ($stable(exp_q) && $stable(mant_q)));
endmodule

// File: rtl/wake_timer_presc.sv
// Module: shift prescaler; divides the tick by 2^exponent and flags each wrap.
// Assumes the counter is wide enough to hold 2^(2^EXP_W - 1) - 1.
module wake_timer_presc #(
    parameter int EXP_W = 5,
    localparam int PRE_W = 1 << EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [EXP_W-1:0] exp_q,
    output logic             pre_wrap
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] lim_m1;

    // Terminal value of the prescaler: 2^R - 1.
    always_comb begin
        lim_m1   = ({{(PRE_W-1){1'b0}}, 1'b1} << exp_q) - 1'b1;
        pre_wrap = run && tick && !restart && (pre_cnt == lim_m1);
    end

    // Prescaler count: cleared on restart or when idle, wraps at its terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
        end
    end

    // R3: count never passes the divider terminal value
    p_pre_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= lim_m1);
    // R7: an idle timer keeps its prescaler at zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0));
endmodule

// File: rtl/wake_timer_mant.sv
// Module: mantissa counter; counts prescaler wraps and registers the expiry pulse.
// Assumes a zero mantissa means the timer never fires.
module wake_timer_mant #(
    parameter int MANT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              pre_wrap,
    input  logic [MANT_W-1:0] mant_q,
    output logic              fire_q
);
    logic [MANT_W-1:0] man_cnt;
    logic              last;

    // Last-step detect: this wrap completes the programmed mantissa.
    always_comb begin
        last = pre_wrap && (mant_q != '0) && (man_cnt == mant_q - 1'b1);
    end

    // Mantissa count and expiry pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            man_cnt <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= last;
            if (pre_wrap) begin
                man_cnt <= last ? '0 : man_cnt + 1'b1;
            end
        end
    end

    // R2: a pulse always follows a prescaler wrap
    p_fire_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(pre_wrap));
    // R4: zero mantissa never fires
    p_no_fire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mant_q == '0) |-> !fire_q);
    // R5: a restart leaves the mantissa count at zero
    p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (man_cnt == '0 && !fire_q));
endmodule

// File: rtl/wake_timer.sv
// Module: top of the wake-up timer; ties settings, prescaler and mantissa counter
// together and keeps the sticky wake flag. Assumes tick_ms is a one-clock strobe.
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int MANT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_ms,
    input  logic        wut_en,
    input  logic        cmd_we,
    input  logic [15:0] cmd_word,
    input  logic        flag_clr,
    output logic        wake_pulse,
    output logic        wake_flag
);
    logic [EXP_W-1:0]  exp_q;
    logic [MANT_W-1:0] mant_q;
    logic              restart;
    logic              run;
    logic              pre_wrap;
    logic              fire_q;
    logic              flag_q;

    wake_timer_cfg #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .exp_q(exp_q), .mant_q(mant_q), .restart(restart)
    );

    // Run gate: counting needs the enable and a nonzero mantissa.
    always_comb begin
        run = wut_en && (mant_q != '0);
    end

    wake_timer_presc #(.EXP_W(EXP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .tick(tick_ms), .exp_q(exp_q), .pre_wrap(pre_wrap)
    );

    wake_timer_mant #(.MANT_W(MANT_W)) u_mant (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .pre_wrap(pre_wrap), .mant_q(mant_q), .fire_q(fire_q)
    );

    // Sticky flag: set by an expiry, cleared by acknowledge, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire_q) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign wake_pulse = fire_q;
    assign wake_flag  = flag_q;

    // R6: every pulse leaves the flag set on the next cycle
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> wake_flag);
    // R7: no pulse while disabled
    p_no_pulse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wut_en) |-> !wake_pulse);
endmodule

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        wut_en = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        flag_clr = 1'b0;
    logic        wake_pulse;
    logic        wake_flag;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wake_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wut_en(wut_en),
        .cmd_we(cmd_we), .cmd_word(cmd_word), .flag_clr(flag_clr),
        .wake_pulse(wake_pulse), .wake_flag(wake_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic write_cmd(input logic [15:0] w);
        @(negedge clk); cmd_we = 1'b1; cmd_word = w;
        @(negedge clk); cmd_we = 1'b0; cmd_word = '0;
    endtask

    // One tick; returns the pulse seen in the following cycle.
    task automatic do_tick(output bit p);
        @(negedge clk); tick_ms = 1'b1;
        @(negedge clk); tick_ms = 1'b0;
        p = wake_pulse;
    endtask

    // Tick n times, return count of pulses and the tick index of the first.
    task automatic tick_n(input int n, output int np, output int first);
        bit p;
        np = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            do_tick(p);
            if (p) begin
                np++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        #4_000_000;
        checks++; failures++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_up();
    end

    initial begin
        int np, first, per, bad;
        bit p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(wake_pulse == 0 && wake_flag == 0, "R9 reset outputs", {wake_pulse, wake_flag}, 0);
        wut_en = 1'b1;
        tick_n(20, np, first);
        check(np == 0, "R9 no pulse with reset settings", np, 0);

        // R2/R8: sweep exponent and mantissa, first and second expiry
        for (int r = 0; r <= 4; r++) begin
            for (int m = 1; m <= 6; m++) begin
                per = m << r;
                write_cmd({3'b111, 5'(r), 8'(m)});
                bad = 0; np = 0;
                for (int i = 1; i <= 2 * per; i++) begin
                    do_tick(p);
                    if (p) np++;
                    if (p != (i % per == 0)) bad++;
                end
                check(bad == 0 && np == 2, $sformatf("R2 R8 period r=%0d m=%0d", r, m), np, 2);
            end
        end

        // R3: largest exponent divides far beyond the test window
        write_cmd({3'b111, 5'd31, 8'd1});
        tick_n(100, np, first);
        check(np == 0, "R3 exponent 31 no early pulse", np, 0);
        // R3: mid exponent exact period
        write_cmd({3'b111, 5'd6, 8'd2});
        tick_n(128, np, first);
        check(np == 1 && first == 128, "R3 exponent 6 mantissa 2", first, 128);

        // R4: zero mantissa never fires
        write_cmd({3'b111, 5'd0, 8'd0});
        tick_n(50, np, first);
        check(np == 0, "R4 zero mantissa", np, 0);

        // R5: rewrite of same command restarts
        write_cmd({3'b111, 5'd2, 8'd3});
        tick_n(7, np, first);
        write_cmd({3'b111, 5'd2, 8'd3});
        tick_n(12, np, first);
        check(np == 1 && first == 12, "R5 rewrite restarts", first, 12);

        // R1: a non-timer command is ignored mid-count
        write_cmd({3'b111, 5'd2, 8'd3});
        tick_n(7, np, first);
        write_cmd(16'h8208);
        tick_n(5, np, first);
        check(np == 1 && first == 5, "R1 other command ignored", first, 5);
        // R1: field positions loaded (exp=1, mant=5 -> 10)
        write_cmd(16'hE105);
        tick_n(10, np, first);
        check(np == 1 && first == 10, "R1 field decode", first, 10);

        // R7: disabled, no pulse; re-enable starts from zero
        write_cmd({3'b111, 5'd1, 8'd4});
        tick_n(5, np, first);
        wut_en = 1'b0;
        tick_n(20, np, first);
        check(np == 0, "R7 disabled no pulse", np, 0);
        wut_en = 1'b1;
        tick_n(8, np, first);
        check(np == 1 && first == 8, "R7 re-enable from zero", first, 8);

        // R6: flag holds, then clears
        repeat (3) @(negedge clk);
        check(wake_flag == 1, "R6 flag held", wake_flag, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check(wake_flag == 0, "R6 flag cleared", wake_flag, 0);
        // R6: set wins over clear in the same cycle
        write_cmd({3'b111, 5'd0, 8'd1});
        @(negedge clk); tick_ms = 1'b1;
        @(negedge clk); tick_ms = 1'b0; flag_clr = 1'b1;
        check(wake_pulse == 1, "R2 pulse before flag", wake_pulse, 1);
        @(negedge clk); flag_clr = 1'b0;
        check(wake_flag == 1, "R6 set wins over clear", wake_flag, 1);

        finish_up();
    end
endmodule